// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken, given only its program counter. Two component predictors are looked up together on every request. The first is a per-branch table of saturating counters, indexed by the low bits of the PC. The second is a correlating table whose index joins the recent global outcome history with low PC bits, so the same branch can learn a different direction for each pattern of preceding outcomes. A third table of saturating counters, also indexed by the PC, picks which of the two answers is driven out.

The lookup port is purely combinational from the stored state. When the branch resolves, the pipeline presents the PC again, the real outcome, and the two component answers it was given at lookup time. The counters are trained on that update port. The global outcome history advances with the real outcome, and the selector is trained only when the two components gave different answers. Table sizes, counter widths and history length are parameters.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every component counter holds the weakly not-taken value, every selector counter holds the weakly local value and the history is zero, so every lookup returns not-taken on all three direction outputs.
- R2: The local counter for a PC sits at index pc[LIDX_W-1:0]. An update moves it one step toward the outcome, and its direction is its most significant bit. From the strongly taken value, two consecutive not-taken updates are needed to flip the prediction.
- R3: The global counter is addressed by {history, pc[GPC_W-1:0]}, with the history in the upper bits. Updates use the history held in the cycle of the update, before that update shifts it.
- R4: On each update the history shifts left by one and the outcome enters bit 0; the oldest bit is dropped.
- R5: The selector counter at index pc[SIDX_W-1:0] changes only when the two reported component predictions differ. It steps up (toward global) when the global prediction matched the outcome and down otherwise. Its most significant bit set selects the global prediction for pred_taken, clear selects the local one.
- R6: When the local and global predictions agree, pred_taken equals them whatever the selector state.
- R7: Counters saturate: a not-taken update at the lowest value and a taken update at the highest value leave the counter unchanged.
- R8: A lookup in the same cycle as an update sees the state from before that update; the new state is visible from the next cycle.
- R9: In a cycle without upd_valid no counter and no history bit changes, so a repeated lookup of the same PC returns the same three directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Final direction chosen by the selector |
| pred_local | output | 1 | Direction from the per-branch table |
| pred_global | output | 1 | Direction from the history-correlated table |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_local_pred | input | 1 | Local direction given at lookup time |
| upd_global_pred | input | 1 | Global direction given at lookup time |

## Verification
A wrong counter value stays hidden until its entry is looked up and, for a counter one step off, until the counter crosses its midpoint, so the bench looks up every trained entry and drives counters across both saturation limits. A wrong history bit sends the next global lookup to a different entry and shows on pred_global in the cycle after the update that wrote it, provided the two entries hold different values. A wrong selector state shows on pred_taken only when the two components disagree, so the bench compares all three outputs against its own model on every cycle of a long mixed stream.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // One step of a saturating counter toward the given direction.
  function automatic int unsigned sat_step(int unsigned cur, logic up, int unsigned maxv);
    if (up)
      return (cur >= maxv) ? maxv : cur + 1;
    else
      return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Value just below the midpoint: weakly not-taken / weakly local.
  function automatic int unsigned weak_low(int unsigned width);
    return (1 << (width - 1)) - 1;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_dir,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int unsigned MAXV = (1 << CTR_W) - 1;
  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(tp_pkg::weak_low(CTR_W));

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_next;

  always_comb begin
    ctr_next = CTR_W'(tp_pkg::sat_step({{(32-CTR_W){1'b0}}, ctr_q[wr_idx]}, wr_up, MAXV));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_next;
    end
  end

  assign rd_dir = ctr_q[rd_idx][CTR_W-1];
endmodule

// File: rtl/tp_hist.sv
module tp_hist #(
  parameter int H_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_bit,
  output logic [H_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (shift_en) begin
      if (H_W == 1) hist <= H_W'(shift_bit);
      else          hist <= {hist[H_W-2:0], shift_bit};
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 6,
  parameter int GHIST_W = 4,
  parameter int GPC_W   = 4,
  parameter int SIDX_W  = 6,
  parameter int CTR_W   = 2,
  parameter int SEL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  localparam int GIDX_W = GHIST_W + GPC_W;

  logic [GHIST_W-1:0] ghist;
  logic [GIDX_W-1:0]  glb_rd_idx;
  logic [GIDX_W-1:0]  glb_wr_idx;
  logic               sel_global;
  logic               upd_disagree;
  logic               sel_wr_en;
  logic               sel_step_up;

  assign glb_rd_idx   = {ghist, pred_pc[GPC_W-1:0]};
  assign glb_wr_idx   = {ghist, upd_pc[GPC_W-1:0]};
  assign upd_disagree = upd_local_pred ^ upd_global_pred;
  assign sel_wr_en    = upd_valid & upd_disagree;
  assign sel_step_up  = (upd_global_pred == upd_taken);

  tp_ctr_table #(.IDX_W(LIDX_W), .CTR_W(CTR_W)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_pc[LIDX_W-1:0]), .rd_dir(pred_local),
    .wr_en(upd_valid), .wr_idx(upd_pc[LIDX_W-1:0]), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GIDX_W), .CTR_W(CTR_W)) u_global (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(glb_rd_idx), .rd_dir(pred_global),
    .wr_en(upd_valid), .wr_idx(glb_wr_idx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(SIDX_W), .CTR_W(SEL_W)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_pc[SIDX_W-1:0]), .rd_dir(sel_global),
    .wr_en(sel_wr_en), .wr_idx(upd_pc[SIDX_W-1:0]), .wr_up(sel_step_up)
  );

  tp_hist #(.H_W(GHIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken), .hist(ghist)
  );

  assign pred_taken = sel_global ? pred_global : pred_local;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    pred_pc,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghist
);
  // R6
  agree_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist[0] == $past(upd_taken)) &&
                  ((GHIST_W < 2) || (ghist >> 1) == ($past(ghist) & ((1 << (GHIST_W-1)) - 1))));

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  // R9
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(pred_pc) ||
                    ($stable(pred_taken) && $stable(pred_local) && $stable(pred_global))));
endmodule

bind tourney_predictor tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (.*);

// File: tb/tourney_predictor_bench.sv
`timescale 1ns/1ps
module tourney_predictor_bench;
  localparam int PC_W = 32, LIDX_W = 6, GHIST_W = 4, GPC_W = 4, SIDX_W = 6;
  localparam int LDEPTH = 1 << LIDX_W;
  localparam int GDEPTH = 1 << (GHIST_W + GPC_W);
  localparam int SDEPTH = 1 << SIDX_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic pred_taken, pred_local, pred_global;
  logic upd_valid = 0, upd_taken = 0, upd_local_pred = 0, upd_global_pred = 0;

  always #4 clk = ~clk;

  tourney_predictor u_tourney_predictor (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int lc[LDEPTH], gc[GDEPTH], sc[SDEPTH];
  int hist;
  logic got_t, got_l, got_g;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gidx(int pc, int h);
    return (h << GPC_W) | (pc & ((1 << GPC_W) - 1));
  endfunction
  function automatic int mv(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction
  function automatic bit m_loc(int pc); return lc[pc % LDEPTH] >= 2; endfunction
  function automatic bit m_glb(int pc); return gc[gidx(pc, hist)] >= 2; endfunction
  function automatic bit m_sel(int pc); return sc[pc % SDEPTH] >= 2; endfunction

  task automatic model_reset();
    foreach (lc[i]) lc[i] = 1;
    foreach (gc[i]) gc[i] = 1;
    foreach (sc[i]) sc[i] = 1;
    hist = 0;
  endtask

  // Entered just after a falling edge; leaves just after the next falling edge.
  task automatic cycle(int pc, bit uv, int upc, bit ut, bit ul, bit ug);
    bit el, eg, et;
    pred_pc = PC_W'(pc); upd_valid = uv; upd_pc = PC_W'(upc);
    upd_taken = ut; upd_local_pred = ul; upd_global_pred = ug;
    #1;
    el = m_loc(pc); eg = m_glb(pc); et = m_sel(pc) ? eg : el;
    got_t = pred_taken; got_l = pred_local; got_g = pred_global;
    chk("R2 local", int'(got_l), int'(el));
    chk("R3 R4 global", int'(got_g), int'(eg));
    chk("R5 final", int'(got_t), int'(et));
    if (el == eg) chk("R6 agree", int'(got_t), int'(el));
    @(posedge clk);
    if (uv) begin
      lc[upc % LDEPTH] = mv(lc[upc % LDEPTH], ut);
      gc[gidx(upc, hist)] = mv(gc[gidx(upc, hist)], ut);
      if (ul != ug) sc[upc % SDEPTH] = mv(sc[upc % SDEPTH], ug == ut);
      hist = ((hist << 1) | int'(ut)) & ((1 << GHIST_W) - 1);
    end
    @(negedge clk);
  endtask

  task automatic idle(int pc); cycle(pc, 0, 0, 0, 0, 0); endtask
  task automatic train(int pc, bit t); cycle(pc, 1, pc, t, m_loc(pc), m_glb(pc)); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything not-taken after reset
    for (int p = 0; p < 8; p++) begin
      idle(p * 7);
      chk("R1 reset taken", int'(got_t), 0);
      chk("R1 reset local", int'(got_l), 0);
      chk("R1 reset global", int'(got_g), 0);
    end
    // R2: hysteresis from strongly taken
    train(5, 1); idle(5); chk("R2 one taken", int'(got_l), 1);
    train(5, 1); train(5, 0); idle(5); chk("R2 first miss holds", int'(got_l), 1);
    train(5, 0); idle(5); chk("R2 second miss flips", int'(got_l), 0);
    // R7: saturation at both ends
    train(9, 0); train(9, 0); train(9, 0); train(9, 1); idle(9);
    chk("R7 low saturation", int'(got_l), 0);
    for (int k = 0; k < 4; k++) train(11, 1);
    train(11, 0); train(11, 0); idle(11);
    chk("R7 high saturation", int'(got_l), 0);
    // R8: same-cycle lookup sees old state
    cycle(30, 1, 30, 1, 0, 0); chk("R8 old state", int'(got_l), 0);
    idle(30); chk("R8 new state", int'(got_l), 1);
    // R5: selector trained toward global on disagreement
    cycle(20, 1, 20, 0, 1, 0);
    cycle(20, 1, 20, 1, 1, 1);
    idle(20);
    chk("R5 selector global", int'(m_sel(20)), 1);
    chk("R5 final follows global", int'(got_t), int'(got_g));
    // R9: idle cycles keep outputs
    idle(5);
    begin
      logic t0, l0, g0;
      t0 = got_t; l0 = got_l; g0 = got_g;
      for (int k = 0; k < 3; k++) begin
        idle(5);
        chk("R9 hold taken", int'(got_t), int'(t0));
        chk("R9 hold local", int'(got_l), int'(l0));
        chk("R9 hold global", int'(got_g), int'(g0));
      end
    end
    // Mixed stream against the model
    for (int n = 0; n < 4000; n++) begin
      int p, u;
      bit t;
      p = int'($urandom_range(0, 63));
      u = int'($urandom_range(0, 63));
      t = ($urandom_range(0, 99) < 65);
      if ($urandom_range(0, 3) == 0) idle(p);
      else if ($urandom_range(0, 3) == 0)
        cycle(p, 1, u, t, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else
        cycle(p, 1, u, t, m_loc(u), m_glb(u));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule